// File: doc/BRIEF.md
# Self-Checking Duplicated-Sum Adder with Error Hold

This block adds two N-bit operands and a carry-in in a purely combinational datapath and stores the result in an output register. Every sum bit is formed twice, on two structurally different XOR paths. An online checker watches the datapath in two ways. It compares the two sum copies. It also compares the parity of the primary sum copy with a parity predicted from the operand parities and the internal carry vector.

When either check fails, the output register skips its load in that cycle and keeps the last result it took without error. It goes on keeping it for as long as the error lasts. In the first clean cycle it loads again from the inputs present in that cycle, with no reset and no restart. A transient fault therefore never reaches the stored result.

The hold is a synchronous load enable, not a gated clock. An error flag is registered in the same edge as the data. A sticky status bit records that any error was seen and stays set until it is cleared. Fault-injection inputs can flip any bit of either sum copy, or the carry tap feeding any sum bit, so that detection and hold can be exercised.

Top module: `sbd_adder_top`

## Requirements
- R1: With no fault injected, after each rising clock edge {cout_o, sum_o} equals a_i + b_i + cin_i as applied before that edge, taken as a WIDTH+1 bit result.
- R2: Flipping any bit of sum copy A (inj_sum_a_i) or of sum copy B (inj_sum_b_i), with the two masks unequal, sets err_o after the next edge.
- R3: Flipping the carry tap into any single sum bit (inj_carry_i, one bit set) sets err_o after the next edge. The same holds for a flip of one bit position in both sum copies at once, which the copy comparison cannot see. Both cases are caught by the parity check.
- R4: In a cycle in which an error is detected, sum_o and cout_o keep the value they held before the edge.
- R5: Across several consecutive error cycles, with operands changing, sum_o and cout_o keep the last value loaded without error.
- R6: In the first cycle with no fault after an error, the register loads the sum of that cycle's inputs, and err_o returns to 0.
- R7: err_sticky_o is set by any detected error and stays set until a clean edge with err_clr_i high clears it. If an error and err_clr_i occur in the same cycle, the bit stays set.
- R8: While rst_ni is low, sum_o, cout_o, err_o and err_sticky_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry-in |
| inj_sum_a_i | input | WIDTH | Per-bit flip of sum copy A |
| inj_sum_b_i | input | WIDTH | Per-bit flip of sum copy B |
| inj_carry_i | input | WIDTH | Per-bit flip of the carry tap into each sum bit |
| err_clr_i | input | 1 | Clears the sticky error bit |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry-out |
| err_o | output | 1 | Registered error flag for the last cycle |
| err_sticky_o | output | 1 | Sticky record of any detected error |

## Verification
The bench builds the block with WIDTH set to 8. At that width it can sweep a single flip through every position of copy A, of copy B, of both copies together and of the carry tap, while still covering the all-ones and carry-out corner cases in a few hundred cycles. The expected register contents come from a model that holds its value whenever the injected masks predict a copy mismatch or odd parity. Each hold is therefore checked against the previous clean result and not against the current inputs.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  typedef struct packed {
    logic dup_mis;
    logic par_mis;
  } chk_flags_t;

  function automatic logic any_err(chk_flags_t f);
    return f.dup_mis | f.par_mis;
  endfunction
endpackage

// File: rtl/sbd_adder_core.sv
module sbd_adder_core #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [WIDTH-1:0] inj_sum_a_i,
  input  logic [WIDTH-1:0] inj_sum_b_i,
  input  logic [WIDTH-1:0] inj_carry_i,
  output logic [WIDTH-1:0] sum_a_o,
  output logic [WIDTH-1:0] sum_b_o,
  output logic [WIDTH-1:0] carry_o,
  output logic             cout_o
);
  logic [WIDTH:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic prop, gen, c_tap, half_b;
    assign prop = a_i[i] ^ b_i[i];
    assign gen  = a_i[i] & b_i[i];
    assign c[i+1] = gen | (prop & c[i]);
    // fault on the sum-side tap only; the chain stays intact
    assign c_tap = c[i] ^ inj_carry_i[i];
    assign sum_a_o[i] = prop ^ c_tap ^ inj_sum_a_i[i];
    // second half-sum path with a different structure
    assign half_b = (a_i[i] | b_i[i]) & ~gen;
    assign sum_b_o[i] = half_b ^ c_tap ^ inj_sum_b_i[i];
  end

  assign carry_o = c[WIDTH-1:0];
  assign cout_o  = c[WIDTH];
endmodule

// File: rtl/sbd_check.sv
module sbd_check
  import sbd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] sum_a_i,
  input  logic [WIDTH-1:0] sum_b_i,
  input  logic [WIDTH-1:0] carry_i,
  output chk_flags_t       flags_o
);
  logic par_pred, par_act;

  assign par_pred = (^a_i) ^ (^b_i) ^ (^carry_i);
  assign par_act  = ^sum_a_i;

  assign flags_o.dup_mis = |(sum_a_i ^ sum_b_i);
  assign flags_o.par_mis = par_pred ^ par_act;
endmodule

// File: rtl/sbd_hold_reg.sv
module sbd_hold_reg #(
  parameter int DW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/sbd_err_status.sv
module sbd_err_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic clr_i,
  output logic err_o,
  output logic sticky_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      err_o    <= err_i;
      sticky_o <= (sticky_o & ~clr_i) | err_i; // set wins over clear
    end
  end
endmodule

// File: rtl/sbd_adder_top.sv
module sbd_adder_top
  import sbd_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [WIDTH-1:0] inj_sum_a_i,
  input  logic [WIDTH-1:0] inj_sum_b_i,
  input  logic [WIDTH-1:0] inj_carry_i,
  input  logic             err_clr_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             err_o,
  output logic             err_sticky_o
);
  localparam int DW = WIDTH + 1;

  logic [WIDTH-1:0] sum_a, sum_b, carry_v;
  logic             cout_c;
  chk_flags_t       flags;
  logic             err_c;
  logic [DW-1:0]    res_q;

  sbd_adder_core #(.WIDTH(WIDTH)) u_core (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .inj_sum_a_i(inj_sum_a_i), .inj_sum_b_i(inj_sum_b_i), .inj_carry_i(inj_carry_i),
    .sum_a_o(sum_a), .sum_b_o(sum_b), .carry_o(carry_v), .cout_o(cout_c)
  );

  sbd_check #(.WIDTH(WIDTH)) u_chk (
    .a_i(a_i), .b_i(b_i), .sum_a_i(sum_a), .sum_b_i(sum_b),
    .carry_i(carry_v), .flags_o(flags)
  );

  assign err_c = any_err(flags);

  // load enable in place of a gated slave clock
  sbd_hold_reg #(.DW(DW)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(~err_c),
    .d_i({cout_c, sum_a}), .q_o(res_q)
  );

  sbd_err_status u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_i(err_c), .clr_i(err_clr_i),
    .err_o(err_o), .sticky_o(err_sticky_o)
  );

  assign sum_o  = res_q[WIDTH-1:0];
  assign cout_o = res_q[WIDTH];
endmodule

// File: rtl/sbd_adder_sva.sv
module sbd_adder_sva #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] inj_sum_a_i,
  input logic [WIDTH-1:0] inj_sum_b_i,
  input logic [WIDTH-1:0] inj_carry_i,
  input logic             err_c,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             err_o,
  input logic             err_sticky_o
);
  logic [WIDTH:0] ref_sum;
  logic           no_inj;
  assign ref_sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign no_inj  = (inj_sum_a_i == '0) && (inj_sum_b_i == '0) && (inj_carry_i == '0);

  // R1
  load_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_inj |=> ({cout_o, sum_o} == $past(ref_sum)));

  // R2
  dup_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_sum_a_i != inj_sum_b_i) |=> err_o);

  // R3
  carry_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(inj_carry_i) == 1 && inj_sum_a_i == '0 && inj_sum_b_i == '0) |=> err_o);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_c |=> ($stable(sum_o) && $stable(cout_o)));

  // R6
  clean_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_inj |=> !err_o);

  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_sticky_o);
endmodule

bind sbd_adder_top sbd_adder_sva #(.WIDTH(WIDTH)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
  .inj_sum_a_i(inj_sum_a_i), .inj_sum_b_i(inj_sum_b_i), .inj_carry_i(inj_carry_i),
  .err_c(err_c), .sum_o(sum_o), .cout_o(cout_o), .err_o(err_o),
  .err_sticky_o(err_sticky_o)
);

// File: tb/sbd_adder_tb.sv
`timescale 1ns/1ps
module sbd_adder_top_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0, ia = '0, ib = '0, ic = '0;
  logic         cin = 1'b0, clr = 1'b0;
  logic [W-1:0] sum;
  logic         cout, err, sticky;

  int total = 0;
  int bad = 0;
  logic [W:0] exp_res = '0;
  logic       exp_sticky = 1'b0;

  always #10 clk = ~clk;

  sbd_adder_top #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
    .inj_sum_a_i(ia), .inj_sum_b_i(ib), .inj_carry_i(ic), .err_clr_i(clr),
    .sum_o(sum), .cout_o(cout), .err_o(err), .err_sticky_o(sticky)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // one clock: drive at negedge, check after the edge
  task automatic step(input logic [W-1:0] ta, tb, input logic tcin,
                      input logic [W-1:0] tia, tib, tic, input logic tclr,
                      input string req_d, input string req_e);
    logic e;
    @(negedge clk);
    a = ta; b = tb; cin = tcin; ia = tia; ib = tib; ic = tic; clr = tclr;
    e = (tia != tib) || (^(tia ^ tic));
    if (!e) exp_res = {1'b0, ta} + {1'b0, tb} + {{W{1'b0}}, tcin};
    exp_sticky = e | (exp_sticky & ~tclr);
    @(posedge clk); #2;
    chk({cout, sum} == exp_res, req_d, "result", {23'd0, cout, sum}, {23'd0, exp_res});
    chk(err == e, req_e, "err", {31'd0, err}, {31'd0, e});
    chk(sticky == exp_sticky, "R7", "sticky", {31'd0, sticky}, {31'd0, exp_sticky});
  endtask

  task automatic t_reset;
    #2;
    chk(sum == '0 && cout == 1'b0, "R8", "reset result", {23'd0, cout, sum}, 32'd0);
    chk(err == 1'b0 && sticky == 1'b0, "R8", "reset flags", {30'd0, err, sticky}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_plain;
    logic [W-1:0] x = 8'h3c, y = 8'h91;
    step(8'h00, 8'h00, 1'b0, '0, '0, '0, 1'b0, "R1", "R1");
    step(8'hff, 8'h01, 1'b0, '0, '0, '0, 1'b0, "R1", "R1");
    step(8'hff, 8'hff, 1'b1, '0, '0, '0, 1'b0, "R1", "R1");
    step(8'h55, 8'haa, 1'b0, '0, '0, '0, 1'b0, "R1", "R1");
    step(8'h55, 8'haa, 1'b1, '0, '0, '0, 1'b0, "R1", "R1");
    for (int k = 0; k < 40; k++) begin
      x = x * 8'd13 + 8'd7; y = y * 8'd29 + 8'd3;
      step(x, y, x[0] ^ y[3], '0, '0, '0, 1'b0, "R1", "R1");
    end
  endtask

  task automatic t_sum_flip;
    for (int i = 0; i < W; i++) begin
      step(8'h12 + 8'(i), 8'h34, 1'b0, '0, '0, '0, 1'b0, "R1", "R1");
      step(8'hf0, 8'h0f + 8'(i), 1'b1, 8'(1 << i), '0, '0, 1'b0, "R4", "R2");
      step(8'h21, 8'h43 + 8'(i), 1'b0, '0, 8'(1 << i), '0, 1'b0, "R4", "R2");
    end
  endtask

  task automatic t_carry_flip;
    for (int i = 0; i < W; i++) begin
      step(8'h7f, 8'(i), 1'b1, '0, '0, '0, 1'b0, "R1", "R1");
      step(8'hff, 8'h01, 1'b1, '0, '0, 8'(1 << i), 1'b0, "R4", "R3");
      step(8'h5a, 8'h3c, 1'b0, 8'(1 << i), 8'(1 << i), '0, 1'b0, "R4", "R3");
    end
  endtask

  task automatic t_hold_run;
    step(8'hc8, 8'h64, 1'b1, '0, '0, '0, 1'b0, "R1", "R1");
    step(8'h01, 8'h02, 1'b0, 8'h04, '0, '0, 1'b0, "R5", "R2");
    step(8'h10, 8'h20, 1'b1, '0, '0, 8'h80, 1'b0, "R5", "R3");
    step(8'hff, 8'hff, 1'b1, '0, 8'h01, '0, 1'b0, "R5", "R2");
    step(8'h99, 8'h11, 1'b0, 8'h20, 8'h20, '0, 1'b0, "R5", "R3");
  endtask

  task automatic t_resume;
    step(8'h40, 8'h40, 1'b0, 8'h02, '0, '0, 1'b0, "R4", "R2");
    step(8'hfe, 8'h03, 1'b1, '0, '0, '0, 1'b0, "R6", "R6");
    step(8'h80, 8'h80, 1'b0, '0, '0, 8'h08, 1'b0, "R4", "R3");
    step(8'h0a, 8'h0b, 1'b0, '0, '0, '0, 1'b0, "R6", "R6");
  endtask

  task automatic t_sticky;
    step(8'h01, 8'h01, 1'b0, 8'h01, '0, '0, 1'b0, "R4", "R2");
    step(8'h02, 8'h02, 1'b0, '0, '0, '0, 1'b0, "R7", "R6");
    step(8'h03, 8'h03, 1'b0, '0, '0, '0, 1'b0, "R7", "R6");
    step(8'h04, 8'h04, 1'b0, '0, '0, '0, 1'b1, "R7", "R6");
    step(8'h05, 8'h05, 1'b0, '0, '0, '0, 1'b0, "R7", "R6");
    step(8'h06, 8'h06, 1'b0, '0, 8'h40, '0, 1'b1, "R7", "R2");
    step(8'h07, 8'h07, 1'b0, '0, '0, '0, 1'b0, "R7", "R6");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_sum_flip();
    t_carry_flip();
    t_hold_run();
    t_resume();
    t_sticky();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule